// File: doc/BRIEF.md
# PWM-Locked ADC Trigger and Interrupt Scheduler

This block places current-sense sampling and the control interrupt on the timeline of a center-aligned PWM carrier. It watches the carrier counter value and its count direction. It issues a one-cycle ADC conversion start at two points in each carrier period: one compare value on the rising slope and another on the falling slope. Because the sampling instants follow the carrier, the readings land away from the power-stage switching edges. Feedback is sampled twice per carrier period, so the sample rate is double the interrupt rate when the interval is two.

After a conversion, the ADC side raises a latch-enable once the result is stable. Each rising edge of that latch-enable is one latch event. A down-counter loaded from a software interval register counts these events. The control interrupt fires only on a latch event, and only when that event uses up the interval. The control routine therefore always gets a guaranteed number of sampling slots. The interrupt stays high until software clears it. The compare values go through shadow copies that are refreshed only when the carrier is at zero, so a write in the middle of a period can neither skip a sample nor create an extra one.

Top module: `pwm_adc_sched`

## Requirements
- R1: One cycle after a clock edge at which `pwm_dir_up` is 1 and `pwm_cnt` equals the active rising-slope compare value, `adc_start` is high.
- R2: One cycle after a clock edge at which `pwm_dir_up` is 0 and `pwm_cnt` equals the active falling-slope compare value, `adc_start` is high. R1 and R2 together give two starts per carrier period.
- R3: Each compare match gives exactly one `adc_start` cycle, however many consecutive edges the carrier holds the matching value and direction. A new pulse needs at least one non-matching edge first.
- R4: The active compare values are copied from `trig_up_val` and `trig_dn_val` only at edges where `pwm_cnt` is 0. At any other edge, a change to those inputs has no effect on which counter value triggers.
- R5: Reset (asynchronous, active-low `rst_n`) sets `adc_start` and `irq_req` to 0. It also sets both active compare values to 0 and the remaining interval to 0.
- R6: A latch event is a rising edge of `latch_en`, seen as high at one edge and low at the edge before it. A `latch_en` held high counts once. `irq_req` can go from 0 to 1 only in the cycle after a latch event.
- R7: On a latch event, if the remaining interval is 0 or 1, the interrupt fires and the remaining interval reloads from `irq_ivl`. Otherwise the remaining interval decreases by one. With `irq_ivl` = N ≥ 1 the interrupt fires on every Nth event, and `irq_ivl` = 0 behaves like 1.
- R8: `irq_req` is a level that stays high until an edge with `irq_clr` = 1 clears it. If a clear and a fire occur at the same edge, the clear wins and `irq_req` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cnt | input | CNT_W | Carrier counter value |
| pwm_dir_up | input | 1 | Carrier direction: 1 counting up, 0 counting down |
| trig_up_val | input | CNT_W | Rising-slope compare value (shadowed) |
| trig_dn_val | input | CNT_W | Falling-slope compare value (shadowed) |
| irq_ivl | input | IVL_W | Interrupt interval in latch events |
| latch_en | input | 1 | ADC result stable indication |
| irq_clr | input | 1 | Interrupt clear strobe |
| adc_start | output | 1 | One-cycle conversion start pulse |
| irq_req | output | 1 | Level interrupt request |

## Verification
The case hardest to reach is a clear that arrives at the same edge as a fire. The remaining interval cannot be seen at the ports, so the stimulus first sends latch pulses until an interrupt shows. That puts the counter in a known reloaded state. Then, with an interval of one, it drives the latch rising edge and the clear together. The mid-period compare rewrite is reached by running a partial carrier ramp that never touches zero. A second ramp then passes through zero, and the bench records the counter value at which each start pulse was issued.

// File: rtl/pas_pkg.sv
package pas_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } carrier_dir_e;

    localparam int NUM_CH = 2;
    localparam int CH_UP  = 0;
    localparam int CH_DN  = 1;
endpackage

// File: rtl/pas_trig_shadow.sv
module pas_trig_shadow #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] up_wr,
    input  logic [CNT_W-1:0] dn_wr,
    output logic [CNT_W-1:0] up_act,
    output logic [CNT_W-1:0] dn_act
);
    typedef struct packed {
        logic [CNT_W-1:0] up;
        logic [CNT_W-1:0] dn;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic    at_zero;

    always_comb begin
        at_zero = (cnt == '0);
        sh_d    = sh_q;
        if (at_zero) begin
            sh_d.up = up_wr;
            sh_d.dn = dn_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign up_act = sh_q.up;
    assign dn_act = sh_q.dn;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> ($stable(sh_q.up) && $stable(sh_q.dn))); // R4
endmodule

// File: rtl/pas_trig_match.sv
module pas_trig_match
    import pas_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] up_act,
    input  logic [CNT_W-1:0] dn_act,
    output logic             start
);
    typedef struct packed {
        logic [NUM_CH-1:0] prev;
        logic [NUM_CH-1:0] pulse;
    } match_t;

    match_t            m_d, m_q;
    logic [NUM_CH-1:0] hit;
    carrier_dir_e      dir;

    always_comb begin
        dir         = carrier_dir_e'(dir_up);
        hit[CH_UP]  = (dir == DIR_UP)   && (cnt == up_act);
        hit[CH_DN]  = (dir == DIR_DOWN) && (cnt == dn_act);
        m_d.prev    = hit;
        m_d.pulse   = hit & ~m_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign start = |m_q.pulse;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            m_q.pulse[c] |=> !m_q.pulse[c]); // R3
    end

    AST_UP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.pulse[CH_UP] |-> $past(dir_up)); // R1
    AST_DN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.pulse[CH_DN] |-> !$past(dir_up)); // R2
endmodule

// File: rtl/pas_irq_gate.sv
module pas_irq_gate #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_en,
    input  logic [IVL_W-1:0] ivl,
    input  logic             clr,
    output logic             irq
);
    localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

    typedef struct packed {
        logic             latch_prev;
        logic [IVL_W-1:0] remain;
        logic             irq;
    } gate_t;

    gate_t g_d, g_q;
    logic  evt;
    logic  fire;

    always_comb begin
        g_d            = g_q;
        g_d.latch_prev = latch_en;
        evt            = latch_en && !g_q.latch_prev;
        fire           = 1'b0;
        if (evt) begin
            if (g_q.remain <= ONE) begin
                fire       = 1'b1;
                g_d.remain = ivl;
            end else begin
                g_d.remain = g_q.remain - ONE;
            end
        end
        if (clr)       g_d.irq = 1'b0;
        else if (fire) g_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign irq = g_q.irq;

    AST_IRQ_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.irq) |-> $past(latch_en)); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.irq && !clr) |=> g_q.irq); // R8
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !g_q.irq); // R8
    AST_QUIET_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(g_q.remain)); // R7
endmodule

// File: rtl/pwm_adc_sched.sv
module pwm_adc_sched #(
    parameter int CNT_W = 12,
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pwm_cnt,
    input  logic             pwm_dir_up,
    input  logic [CNT_W-1:0] trig_up_val,
    input  logic [CNT_W-1:0] trig_dn_val,
    input  logic [IVL_W-1:0] irq_ivl,
    input  logic             latch_en,
    input  logic             irq_clr,
    output logic             adc_start,
    output logic             irq_req
);
    logic [CNT_W-1:0] up_act;
    logic [CNT_W-1:0] dn_act;

    pas_trig_shadow #(.CNT_W(CNT_W)) i_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (pwm_cnt),
        .up_wr  (trig_up_val),
        .dn_wr  (trig_dn_val),
        .up_act (up_act),
        .dn_act (dn_act)
    );

    pas_trig_match #(.CNT_W(CNT_W)) i_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (pwm_cnt),
        .dir_up (pwm_dir_up),
        .up_act (up_act),
        .dn_act (dn_act),
        .start  (adc_start)
    );

    pas_irq_gate #(.IVL_W(IVL_W)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .ivl      (irq_ivl),
        .clr      (irq_clr),
        .irq      (irq_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!adc_start && !irq_req)); // R5
endmodule

// File: tb/test_pwm_adc_sched.sv
module test_pwm_adc_sched;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 12;
    localparam int IVL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] pwm_cnt = '0;
    logic             pwm_dir_up = 1'b1;
    logic [CNT_W-1:0] trig_up_val = '0;
    logic [CNT_W-1:0] trig_dn_val = '0;
    logic [IVL_W-1:0] irq_ivl = '0;
    logic             latch_en = 1'b0;
    logic             irq_clr = 1'b0;
    logic             adc_start;
    logic             irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // behavioural reference state
    int m_up, m_dn, m_rem;
    bit m_uprev, m_dprev, m_start, m_irq, m_lprev;
    int starts_seen = 0;
    int last_start_cnt = -1;
    int edge_cnt;

    pwm_adc_sched #(.CNT_W(CNT_W), .IVL_W(IVL_W)) i_pwm_adc_sched (
        .clk, .rst_n, .pwm_cnt, .pwm_dir_up, .trig_up_val, .trig_dn_val,
        .irq_ivl, .latch_en, .irq_clr, .adc_start, .irq_req
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit uh, dh, ev, fire;
        if (!rst_n) begin
            m_up = 0; m_dn = 0; m_rem = 0;
            m_uprev = 0; m_dprev = 0; m_start = 0; m_irq = 0; m_lprev = 0;
            return;
        end
        uh = pwm_dir_up && (int'(pwm_cnt) == m_up);
        dh = !pwm_dir_up && (int'(pwm_cnt) == m_dn);
        m_start = (uh && !m_uprev) || (dh && !m_dprev);
        m_uprev = uh; m_dprev = dh;
        if (pwm_cnt == 0) begin
            m_up = int'(trig_up_val);
            m_dn = int'(trig_dn_val);
        end
        ev = latch_en && !m_lprev;
        m_lprev = latch_en;
        fire = 0;
        if (ev) begin
            if (m_rem <= 1) begin fire = 1; m_rem = int'(irq_ivl); end
            else m_rem = m_rem - 1;
        end
        if (irq_clr) m_irq = 0;
        else if (fire) m_irq = 1;
    endtask

    task automatic step();
        @(posedge clk);
        edge_cnt = int'(pwm_cnt);
        model_edge();
        @(negedge clk);
        cycles++;
        check(adc_start == m_start, "R1/R2/R3/R4 adc_start per cycle", adc_start, m_start);
        check(irq_req == m_irq, "R6/R7/R8 irq_req per cycle", irq_req, m_irq);
        if (adc_start) begin
            starts_seen++;
            last_start_cnt = edge_cnt;
        end
    endtask

    // one center-aligned carrier period, latch pulses follow each trigger point
    task automatic carrier_period(input int top, input int lu, input int ld);
        for (int i = 0; i < 2*top; i++) begin
            int c;
            bit up;
            up = (i < top);
            c  = up ? i : 2*top - i;
            pwm_cnt    = CNT_W'(c);
            pwm_dir_up = up;
            latch_en   = (up && c >= lu + 3 && c < lu + 6) ||
                         (!up && c <= ld - 3 && c > ld - 6);
            irq_clr    = irq_req && (c == 1);
            step();
        end
        latch_en = 0;
        irq_clr  = 0;
    endtask

    task automatic latch_pulse(input bit with_clr);
        latch_en = 1; irq_clr = with_clr; step();
        latch_en = 0; irq_clr = 0; step();
    endtask

    task automatic clear_irq();
        irq_clr = 1; step(); irq_clr = 0;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            if (cycles > 100000 && !done) begin
                n_fail++;
                $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 100000);
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        int base;
        // R5: reset state
        rst_n = 0;
        step(); step();
        check(adc_start == 0, "R5 adc_start in reset", adc_start, 0);
        check(irq_req == 0, "R5 irq_req in reset", irq_req, 0);
        rst_n = 1;
        pwm_cnt = 7; pwm_dir_up = 1;
        step();
        check(adc_start == 0 && irq_req == 0, "R5 quiet after release", adc_start, 0);

        // R1 R2: two starts per period after shadows are loaded
        trig_up_val = 10; trig_dn_val = 30; irq_ivl = 2;
        carrier_period(40, 10, 30);
        base = starts_seen;
        carrier_period(40, 10, 30);
        carrier_period(40, 10, 30);
        carrier_period(40, 10, 30);
        check(starts_seen - base == 6, "R1 R2 starts over three periods", starts_seen - base, 6);
        check(last_start_cnt == 30, "R2 last start on falling compare", last_start_cnt, 30);

        // R3: dwell on the compare value
        pwm_dir_up = 1; pwm_cnt = 9; step();
        base = starts_seen;
        pwm_cnt = 10;
        for (int k = 0; k < 5; k++) step();
        check(starts_seen - base == 1, "R3 one start during dwell", starts_seen - base, 1);
        pwm_cnt = 11; step();
        pwm_cnt = 10; step(); step();
        check(starts_seen - base == 2, "R3 re-arm after leaving value", starts_seen - base, 2);
        // R3: dwell on the falling side
        pwm_dir_up = 0; pwm_cnt = 30;
        base = starts_seen;
        for (int k = 0; k < 4; k++) step();
        check(starts_seen - base == 1, "R3 one falling start during dwell", starts_seen - base, 1);

        // R4: write during a period has no effect until zero
        trig_up_val = 20;
        pwm_dir_up = 1;
        base = starts_seen;
        for (int c = 1; c <= 25; c++) begin pwm_cnt = CNT_W'(c); step(); end
        check(starts_seen - base == 1, "R4 single start with old value", starts_seen - base, 1);
        check(last_start_cnt == 10, "R4 old compare still active", last_start_cnt, 10);
        pwm_cnt = 0; step();
        base = starts_seen;
        for (int c = 1; c <= 25; c++) begin pwm_cnt = CNT_W'(c); step(); end
        check(starts_seen - base == 1, "R4 single start with new value", starts_seen - base, 1);
        check(last_start_cnt == 20, "R4 new compare after zero", last_start_cnt, 20);

        // R7: interval of three, synchronise on a fire first
        pwm_dir_up = 0; pwm_cnt = 5;
        if (irq_req) clear_irq();
        irq_ivl = 3;
        for (int k = 0; k < 4 && !irq_req; k++) latch_pulse(0);
        check(irq_req == 1, "R7 fire reached", irq_req, 1);
        clear_irq();
        latch_pulse(0);
        check(irq_req == 0, "R7 no fire after 1 of 3", irq_req, 0);
        latch_pulse(0);
        check(irq_req == 0, "R7 no fire after 2 of 3", irq_req, 0);
        latch_pulse(0);
        check(irq_req == 1, "R7 fire after 3 of 3", irq_req, 1);
        // R8: level held without clear
        for (int k = 0; k < 5; k++) step();
        check(irq_req == 1, "R8 level held", irq_req, 1);
        clear_irq();
        check(irq_req == 0, "R8 cleared", irq_req, 0);

        // R6: held-high latch counts once (interval 2 after a reload)
        irq_ivl = 2;
        latch_pulse(0); latch_pulse(0); latch_pulse(0);
        if (irq_req) clear_irq();
        latch_en = 1;
        for (int k = 0; k < 6; k++) step();
        latch_en = 0; step();
        check(irq_req == 0, "R6 held latch is one event", irq_req, 0);
        latch_pulse(0);
        check(irq_req == 1, "R6 second edge fires", irq_req, 1);
        clear_irq();

        // R7: interval zero behaves as one
        irq_ivl = 0;
        latch_pulse(0); clear_irq();
        latch_pulse(0);
        check(irq_req == 1, "R7 interval zero fires each event", irq_req, 1);
        clear_irq();
        latch_pulse(0);
        check(irq_req == 1, "R7 interval zero fires again", irq_req, 1);

        // R8: clear and fire at the same edge
        latch_en = 1; irq_clr = 1; step();
        check(irq_req == 0, "R8 clear wins over fire", irq_req, 0);
        latch_en = 0; irq_clr = 0; step();
        latch_pulse(0);
        check(irq_req == 1, "R8 fire after contention", irq_req, 1);
        clear_irq();

        // mixed run with interval 2
        irq_ivl = 2; trig_up_val = 15; trig_dn_val = 25;
        carrier_period(32, 15, 25);
        carrier_period(32, 15, 25);
        carrier_period(32, 15, 25);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule